// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block gives a host on a two-wire serial bus access to a small configuration register file. It runs entirely on a fast system clock. Both bus lines are synchronised and oversampled, and start and stop conditions are detected from their edges. The block answers to one fixed 7-bit device address. A write frame carries a register pointer and then any number of data bytes, which land in consecutive registers. A read frame starts with a repeated start and returns consecutive registers for as long as the host keeps acknowledging.

The register space is addressed with eight bits but is sparse. Eleven locations hold storage and are exposed in parallel to the rest of the chip. In some of them, bits are tied to constants. The data line is open-drain, so the block only asks for the line to be pulled low through an output-enable signal. The surrounding pad logic does the pulling.

Top module: `twi_cfg_slave`

## Requirements
- R1: A start (data falling while the clock is high) always restarts address reception, even in the middle of a byte. A stop (data rising while the clock is high) returns the block to idle, and clock pulses after a stop are not acknowledged until the next start.
- R2: The first byte after a start is a 7-bit device address, MSB first, followed by a direction bit (0 = write, 1 = read). Only address 0x69 is acknowledged. On a mismatch the block does not acknowledge and ignores every byte until the next start.
- R3: In a write frame the byte after the device address sets the register pointer. Each later data byte is stored at the pointer, and the pointer then advances by one.
- R4: Every byte the block receives is acknowledged by asserting `sda_oe` during the ninth clock. `sda_oe` only becomes asserted after the clock has been seen falling, never while it is high.
- R5: In a read frame the block shifts out the register at the pointer, MSB first, and advances the pointer after each byte. If the host acknowledges, the next register follows. If the host does not acknowledge, the block releases the line and stays idle until the next start.
- R6: Registers exist at 0x09, 0x0C, 0x12, 0x13, 0x40, 0x41, 0x42, 0x44, 0x45, 0x46 and 0x47. `cfg_o` holds their read values in that order, the first one in bits 7:0.
- R7: After reset every writable bit is zero and `wr_err` is low.
- R8: Some bits always read a constant, whatever is written:
  - 0x09 bits 7:6 = 00
  - 0x12 bits 7:5 = 001 and bits 2:0 = 000
  - 0x40 bits 7:5 = 110
  - 0x46 bits 5:0 = 111111
- R9: A data byte written to an unimplemented address is acknowledged but discarded, and it sets `wr_err`. `wr_err` stays high until reset. Reads from an unimplemented address return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | 1 = pull the data line low |
| wr_err | output | 1 | Sticky flag for a write to an unimplemented address |
| cfg_o | output | 88 | Read values of the eleven registers, 8 bits each |

## Verification
The assertions assume that each bus line stays steady for longer than the synchroniser latency of three system clocks. They also assume that data changes only while the clock is low, except at start and stop, and that the host never sends a stop while the block is driving the line. The bench host holds each clock phase and each data setup for twenty system clocks. It moves data only after the clock has fallen, and it ends every read with a not-acknowledge before the stop, so every frame stays inside those assumptions.

// File: rtl/twi_cfg_slave.sv
module twi_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int NREG = 11,
  parameter logic [NREG*8-1:0] ADDRS = 88'h47_46_45_44_42_41_40_13_12_0C_09,
  parameter logic [NREG*8-1:0] WMASK = 88'hFF_C0_FF_FF_FF_FF_1F_FF_18_FF_3F,
  parameter logic [NREG*8-1:0] FIXED = 88'h00_3F_00_00_00_00_C0_00_20_00_00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic            wr_err,
  output logic [NREG*8-1:0] cfg_o
);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_REG, S_WR, S_RD} st_t;

  logic [1:0] scl_s, sda_s;
  logic       scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_s <= 2'b11; sda_s <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_s[1];
      sda_q <= sda_s[1];
    end

  wire scl      = scl_s[1];
  wire sda      = sda_s[1];
  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start_c  = scl & scl_q & sda_q & ~sda;
  wire stop_c   = scl & scl_q & ~sda_q & sda;

  st_t        st;
  logic [3:0] bitcnt;
  logic [7:0] shreg, tx, ptr;
  logic       rd_mode, m_ack;
  logic [7:0] mem [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_view
    assign cfg_o[i*8 +: 8] = mem[i] | FIXED[i*8 +: 8];
  end

  logic       hit;
  int         hidx;
  logic [7:0] rd_byte;

  always_comb begin
    hit  = 1'b0;
    hidx = 0;
    for (int i = 0; i < NREG; i++)
      if (ADDRS[i*8 +: 8] == ptr) begin
        hit  = 1'b1;
        hidx = i;
      end
    rd_byte = hit ? cfg_o[hidx*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      tx      <= '0;
      ptr     <= '0;
      rd_mode <= 1'b0;
      m_ack   <= 1'b0;
      sda_oe  <= 1'b0;
      wr_err  <= 1'b0;
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (start_c) begin
      st     <= S_DEV;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= S_IDLE;
      sda_oe <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          shreg  <= {shreg[6:0], sda};
          bitcnt <= bitcnt + 4'd1;
        end else if (bitcnt == 4'd8) begin
          bitcnt <= 4'd9;
          m_ack  <= ~sda;
        end
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (st)
            S_DEV:
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe  <= 1'b1;
                rd_mode <= shreg[0];
              end else st <= S_IDLE;
            S_REG: begin
              ptr    <= shreg;
              sda_oe <= 1'b1;
            end
            S_WR: begin
              if (hit) mem[hidx] <= shreg & WMASK[hidx*8 +: 8];
              else     wr_err    <= 1'b1;
              ptr    <= ptr + 8'd1;
              sda_oe <= 1'b1;
            end
            default: begin
              sda_oe <= 1'b0;
              ptr    <= ptr + 8'd1;
            end
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          case (st)
            S_DEV:
              if (rd_mode) begin
                st     <= S_RD;
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end else st <= S_REG;
            S_REG: st <= S_WR;
            S_RD:
              if (m_ack) begin
                tx     <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end else st <= S_IDLE;
            default: ;
          endcase
        end else if (st == S_RD && bitcnt != 4'd0) begin
          sda_oe <= ~tx[6];
          tx     <= {tx[6:0], 1'b0};
        end
      end
    end

endmodule

// File: rtl/twi_cfg_slave_chk.sv
module twi_cfg_slave_chk #(
  parameter int NREG = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            scl_i,
  input logic            sda_oe,
  input logic            wr_err,
  input logic [NREG*8-1:0] cfg_o
);

  logic c0, c1, c2;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c0 <= 1'b1; c1 <= 1'b1; c2 <= 1'b1;
    end else begin
      c0 <= scl_i; c1 <= c0; c2 <= c1;
    end

  // R4
  ack_at_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(!c1 && c2));

  // R3
  cfg_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(!c1 && c2));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_err) |-> wr_err);

  // R9
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_err) |-> $past(!c1 && c2));

  // R8
  fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[7:6] == 2'b00 && cfg_o[23:21] == 3'b001 && cfg_o[18:16] == 3'b000 &&
    cfg_o[39:37] == 3'b110 && cfg_o[77:72] == 6'h3F);

endmodule

bind twi_cfg_slave twi_cfg_slave_chk #(.NREG(NREG)) u_chk (.*);

// File: tb/sim_twi_cfg_slave.sv
module sim_twi_cfg_slave;
  localparam int Q = 20;
  localparam logic [87:0] RST_VIEW = 88'h00_3F_00_00_00_00_C0_00_20_00_00;
  localparam logic [23:0] VEC [0:13] = '{
    24'h09FF3F, 24'h0CA5A5, 24'h12FF38, 24'h120020, 24'h135A5A,
    24'h40FFDF, 24'h4000C0, 24'h41C3C3, 24'h428181, 24'h449696,
    24'h456969, 24'h46003F, 24'h46FFFF, 24'h477E7E};

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, wr_err;
  logic [87:0] cfg_o;
  wire bus_sda = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  twi_cfg_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(bus_sda),
                    .sda_oe(sda_oe), .wr_err(wr_err), .cfg_o(cfg_o));

  int n_run = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [87:0] act, input logic [87:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int idx_of(input logic [7:0] a);
    case (a)
      8'h09: return 0;  8'h0C: return 1;  8'h12: return 2;  8'h13: return 3;
      8'h40: return 4;  8'h41: return 5;  8'h42: return 6;  8'h44: return 7;
      8'h45: return 8;  8'h46: return 9;  default: return 10;
    endcase
  endfunction

  task automatic bus_start;
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b0; tick(Q); m_scl = 1'b0; tick(Q);
  endtask
  task automatic bus_stop;
    m_sda = 1'b0; tick(Q); m_scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
  endtask
  task automatic put_bit(input logic b);
    m_sda = b; tick(Q); m_scl = 1'b1; tick(Q); m_scl = 1'b0; tick(Q);
  endtask
  task automatic get_bit(output logic b);
    m_sda = 1'b1; tick(Q); m_scl = 1'b1; tick(Q/2); b = bus_sda; tick(Q/2); m_scl = 1'b0; tick(Q);
  endtask
  task automatic send(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    ack = ~b;
  endtask
  task automatic recv(input logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) get_bit(d[i]);
    put_bit(~give_ack);
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    bus_start; send(8'hD2, a1); send(a, a2); send(d, a3); bus_stop;
    ok = a1 & a2 & a3;
  endtask
  task automatic rd_reg(input logic [7:0] a, output logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    bus_start; send(8'hD2, a1); send(a, a2);
    bus_start; send(8'hD3, a3); recv(1'b0, d); bus_stop;
    ok = a1 & a2 & a3;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic ok, a1, a2, a3, b;
    logic [7:0] d0, d1, d2, d3;
    tick(10); rst_n = 1'b1; tick(10);

    // R7 R8 reset view
    chk(cfg_o == RST_VIEW, "R7 reset view", cfg_o, RST_VIEW);
    chk(sda_oe == 1'b0 && wr_err == 1'b0, "R7 idle outputs", {sda_oe, wr_err}, 2'b00);

    // R3 R5 R6 R8 single write then readback per vector
    for (int i = 0; i < 14; i++) begin
      logic [7:0] a, w, e;
      {a, w, e} = VEC[i];
      wr_reg(a, w, ok);
      chk(ok, "R4 write acks", ok, 1'b1);
      chk(cfg_o[idx_of(a)*8 +: 8] == e, "R6 R8 cfg_o slice", cfg_o[idx_of(a)*8 +: 8], e);
      rd_reg(a, d0, ok);
      chk(ok && d0 == e, "R5 readback", {ok, d0}, {1'b1, e});
    end

    // R3 burst write 0x44..0x46
    bus_start; send(8'hD2, a1); send(8'h44, a2); send(8'h11, a3); chk(a1 & a2 & a3, "R4 burst acks", {a1,a2,a3}, 3'b111);
    send(8'h22, a1); send(8'h33, a2); bus_stop;
    chk(a1 & a2, "R4 burst data acks", {a1,a2}, 2'b11);
    chk(cfg_o[56 +: 24] == 24'h3F2211, "R3 burst landed", cfg_o[56 +: 24], 24'h3F2211);

    // R5 R9 burst read 0x41..0x44 through a hole at 0x43
    bus_start; send(8'hD2, a1); send(8'h41, a2);
    bus_start; send(8'hD3, a3);
    recv(1'b1, d0); recv(1'b1, d1); recv(1'b1, d2); recv(1'b0, d3);
    chk({d0,d1,d2,d3} == 32'hC3810011, "R5 R9 burst read", {d0,d1,d2,d3}, 32'hC3810011);
    recv(1'b0, d0);
    chk(d0 == 8'hFF, "R5 released after nack", d0, 8'hFF);
    bus_stop;

    // R2 wrong device address
    bus_start; send(8'hD0, a1); send(8'h0C, a2); send(8'h00, a3); bus_stop;
    chk({a1,a2,a3} == 3'b000, "R2 no ack on mismatch", {a1,a2,a3}, 3'b000);
    chk(cfg_o[8 +: 8] == 8'hA5, "R2 register untouched", cfg_o[8 +: 8], 8'hA5);

    // R1 start inside a byte restarts
    bus_start; send(8'hD2, a1); send(8'h0C, a2);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_start; send(8'hD2, a1); send(8'h13, a2); send(8'h77, a3); bus_stop;
    chk(a1 & a2 & a3, "R1 restart acks", {a1,a2,a3}, 3'b111);
    chk(cfg_o[8 +: 8] == 8'hA5 && cfg_o[24 +: 8] == 8'h77, "R1 restart data",
        {cfg_o[8 +: 8], cfg_o[24 +: 8]}, 16'hA577);

    // R1 no response after stop without a start
    m_scl = 1'b0; tick(Q);
    for (int i = 7; i >= 0; i--) put_bit(d0[i] | 1'b1 ? 8'hD2 >> i : 1'b0);
    get_bit(b);
    bus_stop;
    chk(b == 1'b1, "R1 ignored after stop", b, 1'b1);

    // R9 unimplemented write
    chk(wr_err == 1'b0, "R9 flag clear before", wr_err, 1'b0);
    wr_reg(8'h20, 8'h55, ok);
    chk(ok && wr_err == 1'b1, "R9 flag set, byte acked", {ok, wr_err}, 2'b11);
    wr_reg(8'h0C, 8'h5C, ok);
    chk(wr_err == 1'b1 && cfg_o[8 +: 8] == 8'h5C, "R9 flag sticky", {wr_err, cfg_o[8 +: 8]}, 9'h15C);
    rd_reg(8'h20, d0, ok);
    chk(d0 == 8'h00, "R9 hole reads zero", d0, 8'h00);

    // R7 reset again
    rst_n = 1'b0; tick(3); rst_n = 1'b1; tick(3);
    chk(cfg_o == RST_VIEW && wr_err == 1'b0, "R7 second reset", {cfg_o, wr_err}, {RST_VIEW, 1'b0});

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule